// File: doc/BRIEF.md
# Serial Divide-Ratio Loader

This block takes divide-ratio words for a frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. Bits enter a data shift register, and the most recent bit sits in a separate one-bit select register. When the load strobe is high, the select bit picks one of two holding registers, and that register copies the word. The reference register is 14 bits wide and holds the reference ratio. The main register is 18 bits wide and holds the swallow count and the programmable count. The outputs drive the divider counters directly.

The serial lines are treated as slow signals that are already synchronous to the block's system clock. The block finds a rising serial clock by comparing the current sample with the sample from the previous cycle. Each holding register has a flag that shows it has been written at least once since reset. Two range flags report whether the loaded ratios are legal.

Top module: `divider_loader`

## Requirements
- R1: One bit is shifted per rising edge of `ser_clk`. The shift happens on the first `clk` edge that samples `ser_clk` high after it was sampled low. A `ser_clk` held high shifts nothing more, whatever `ser_data` does.
- R2: The main word is sent as 19 bits in this order: swallow bits 0 to 5, then programmable-count bits 0 to 11 (least significant first), then a select bit of 0.
- R3: The reference word is sent as 15 bits in this order: ratio bits 0 to 13 (least significant first), then a select bit of 1. Only the last 14 data bits before the select bit count.
- R4: On each `clk` edge that samples `ser_load` high, only the register chosen by the current select bit loads. The new value appears on the outputs after that edge.
- R5: While `ser_load` is low, shifting never changes any latched output.
- R6: During reset, every output is 0.
- R7: `ref_valid` and `main_valid` each rise on the first load of their register and then stay high until reset.
- R8: `ref_ok` is high exactly when the reference register is valid and its ratio is at least 5.
- R9: `main_ok` is high exactly when the main register is valid, the programmable count is at least 5, and the swallow count is less than the programmable count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Load strobe |
| ref_ratio | output | 14 | Latched reference ratio |
| swallow | output | 6 | Latched swallow count |
| prog_cnt | output | 12 | Latched programmable count |
| ref_valid | output | 1 | Reference register written since reset |
| main_valid | output | 1 | Main register written since reset |
| ref_ok | output | 1 | Reference ratio is legal |
| main_ok | output | 1 | Main ratios are legal |

## Verification
The bench targets these corner cases:
- **Bit order and field boundaries.** A design that reversed the bit order, or took the reference field from the wrong end of the shift register, would load a mirrored ratio or a shifted one.
- **Serial clock held high.** While the serial clock stays high, the data line toggles. A level-sensitive shifter would add bits and corrupt the next load.
- **Words with leading extra bits.** Some words carry extra bits in front. A design that counted bits instead of using the last ones would load the wrong fields.
- **Loads with the strobe low.** Words are sent with the load strobe low and the outputs are checked for no change. A design that gated on the wrong polarity, or loaded both registers, would change a value it should keep.
- **Range edges.** The bench applies a ratio of 4 against 5, swallow equal to the programmable count, and the all-ones maximum. These cases expose an off-by-one error in the legality flags.

// File: rtl/divload_pkg.sv
// Shared widths and the limit for the serial divide-ratio loader.
// Assumes the swallow and programmable fields together are at least as wide as the reference field.
package divload_pkg;
    localparam int SWALLOW_W = 6;
    localparam int PROG_W    = 12;
    localparam int REF_W     = 14;
    localparam int MIN_RATIO = 5;
endpackage

// File: rtl/divload_shift.sv
// Serial input stage: detects rising edges of the sampled serial clock
// and shifts data in. The newest bit goes to a one-bit select register,
// and the bit it displaces moves into the top of the data register.
// Assumes ser_clk/ser_data are already synchronous to clk.
module divload_shift #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    output logic [DATA_W-1:0] word,
    output logic              sel
);
    logic sclk_q;
    logic step;

    // edge detect of the serial clock against last cycle's sample
    assign step = ser_clk & ~sclk_q;

    // remember the serial clock level
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= ser_clk;
    end

    // shift one bit per detected edge, oldest bit toward index 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            sel  <= 1'b0;
        end else if (step) begin
            word <= {sel, word[DATA_W-1:1]};
            sel  <= ser_data;
        end
    end
endmodule

// File: rtl/divload_latch.sv
// Holding register with a written-once flag. Loads d on every clk edge
// where we is high. Assumes we is already qualified by the select bit.
module divload_latch #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         valid
);
    // capture the word and mark the register as written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            valid <= 1'b0;
        end else if (we) begin
            q     <= d;
            valid <= 1'b1;
        end
    end
endmodule

// File: rtl/divload_range.sv
// Legality flags for the latched ratios. Purely combinational.
// Assumes the valid inputs come from the matching holding registers.
module divload_range #(
    parameter int SW_W  = 6,
    parameter int PG_W  = 12,
    parameter int RF_W  = 14,
    parameter int MINV  = 5
) (
    input  logic            ref_valid,
    input  logic            main_valid,
    input  logic [RF_W-1:0] ref_ratio,
    input  logic [SW_W-1:0] swallow,
    input  logic [PG_W-1:0] prog_cnt,
    output logic            ref_ok,
    output logic            main_ok
);
    localparam int CMP_W = (PG_W > SW_W) ? PG_W : SW_W;

    logic [CMP_W-1:0] sw_ext;
    logic [CMP_W-1:0] pg_ext;

    // widen both counts to one width for the compare
    always_comb begin
        sw_ext = CMP_W'(swallow);
        pg_ext = CMP_W'(prog_cnt);
    end

    // reference ratio must reach the minimum
    assign ref_ok  = ref_valid && (32'(ref_ratio) >= MINV);
    // programmable count must reach the minimum and exceed the swallow count
    assign main_ok = main_valid && (32'(prog_cnt) >= MINV) && (sw_ext < pg_ext);
endmodule

// File: rtl/divider_loader.sv
// Top of the serial divide-ratio loader. One shift stage feeds two
// holding registers. A select bit of 1 loads the reference register
// and 0 loads the main register, while the load strobe is high.
// Assumes the serial inputs are synchronous to clk.
module divider_loader
    import divload_pkg::*;
#(
    parameter int SW_W = SWALLOW_W,
    parameter int PG_W = PROG_W,
    parameter int RF_W = REF_W,
    parameter int MINV = MIN_RATIO
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_clk,
    input  logic            ser_data,
    input  logic            ser_load,
    output logic [RF_W-1:0] ref_ratio,
    output logic [SW_W-1:0] swallow,
    output logic [PG_W-1:0] prog_cnt,
    output logic            ref_valid,
    output logic            main_valid,
    output logic            ref_ok,
    output logic            main_ok
);
    localparam int DATA_W = SW_W + PG_W;
    localparam int REF_LO = DATA_W - RF_W;

    logic [DATA_W-1:0] word;
    logic              sel;
    logic              we_ref;
    logic              we_main;
    logic [DATA_W-1:0] main_q;

    divload_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .word(word), .sel(sel)
    );

    // strobe gated by the decoded select bit
    assign we_ref  = ser_load & sel;
    assign we_main = ser_load & ~sel;

    divload_latch #(.W(RF_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .we(we_ref), .d(word[DATA_W-1:REF_LO]),
        .q(ref_ratio), .valid(ref_valid)
    );

    divload_latch #(.W(DATA_W)) u_main (
        .clk(clk), .rst_n(rst_n), .we(we_main), .d(word),
        .q(main_q), .valid(main_valid)
    );

    // swallow field arrives first and so sits at the low end
    assign swallow  = main_q[SW_W-1:0];
    assign prog_cnt = main_q[DATA_W-1:SW_W];

    divload_range #(.SW_W(SW_W), .PG_W(PG_W), .RF_W(RF_W), .MINV(MINV)) u_range (
        .ref_valid(ref_valid), .main_valid(main_valid), .ref_ratio(ref_ratio),
        .swallow(swallow), .prog_cnt(prog_cnt), .ref_ok(ref_ok), .main_ok(main_ok)
    );
endmodule

// File: rtl/divider_loader_chk.sv
// Timing properties of the loader, checked at its ports.
module divider_loader_chk #(
    parameter int SW_W = 6,
    parameter int PG_W = 12,
    parameter int RF_W = 14,
    parameter int MINV = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ser_load,
    input logic [RF_W-1:0] ref_ratio,
    input logic [SW_W-1:0] swallow,
    input logic [PG_W-1:0] prog_cnt,
    input logic            ref_valid,
    input logic            main_valid,
    input logic            ref_ok,
    input logic            main_ok
);
    // R5
    no_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_load |=> ($stable(ref_ratio) && $stable(swallow) && $stable(prog_cnt)));

    // R4
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_ratio) |-> ($stable(swallow) && $stable(prog_cnt)));

    // R7
    ref_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> ref_valid);

    // R7
    main_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_valid |=> main_valid);

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!ref_valid && !main_valid && ref_ratio == '0));

    // R8
    ref_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_valid || 32'(ref_ratio) < MINV) |-> !ref_ok);

    // R9
    main_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_valid || 32'(prog_cnt) < MINV) |-> !main_ok);
endmodule

bind divider_loader divider_loader_chk #(.SW_W(SW_W), .PG_W(PG_W), .RF_W(RF_W), .MINV(MINV)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_load(ser_load), .ref_ratio(ref_ratio),
    .swallow(swallow), .prog_cnt(prog_cnt), .ref_valid(ref_valid),
    .main_valid(main_valid), .ref_ok(ref_ok), .main_ok(main_ok)
);

// File: tb/divider_loader_test.sv
`timescale 1ns/1ps
module divider_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_load = 1'b0;
    logic [13:0] ref_ratio;
    logic [5:0]  swallow;
    logic [11:0] prog_cnt;
    logic        ref_valid, main_valid, ref_ok, main_ok;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    divider_loader uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .ref_ratio(ref_ratio), .swallow(swallow),
        .prog_cnt(prog_cnt), .ref_valid(ref_valid), .main_valid(main_valid),
        .ref_ok(ref_ok), .main_ok(main_ok)
    );

    // behavioural reference: history of received bits, newest at the back
    logic q[$];
    int   m_ref, m_sw, m_pg;
    bit   m_rv, m_mv, prev_sclk;

    task automatic model_reset();
        q.delete();
        for (int i = 0; i < 19; i++) q.push_back(1'b0);
        m_ref = 0; m_sw = 0; m_pg = 0; m_rv = 0; m_mv = 0; prev_sclk = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            if (ser_load) begin
                if (q[18]) begin
                    m_ref = 0;
                    for (int k = 0; k < 14; k++) m_ref += int'(q[4+k]) << k;
                    m_rv = 1;
                end else begin
                    m_sw = 0; m_pg = 0;
                    for (int k = 0; k < 6; k++)  m_sw += int'(q[k]) << k;
                    for (int k = 0; k < 12; k++) m_pg += int'(q[6+k]) << k;
                    m_mv = 1;
                end
            end
            if (ser_clk && !prev_sclk) begin
                q.push_back(ser_data);
                void'(q.pop_front());
            end
            prev_sclk = ser_clk;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2/R3/R4 model ref_ratio", int'(ref_ratio), m_ref);
            chk("R2/R4 model swallow", int'(swallow), m_sw);
            chk("R2/R4 model prog_cnt", int'(prog_cnt), m_pg);
            chk("R7 model ref_valid", int'(ref_valid), int'(m_rv));
            chk("R7 model main_valid", int'(main_valid), int'(m_mv));
            chk("R8 model ref_ok", int'(ref_ok), int'(m_rv && m_ref >= 5));
            chk("R9 model main_ok", int'(main_ok), int'(m_mv && m_pg >= 5 && m_sw < m_pg));
        end
    end

    task automatic send_bit(logic b);
        @(negedge clk); ser_data = b; ser_clk = 1'b0;
        @(negedge clk); ser_clk = 1'b1;
        @(negedge clk);
        @(negedge clk); ser_clk = 1'b0;
    endtask

    task automatic send_bits(int v, int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic send_ref(int r);
        send_bits(r, 14); send_bit(1'b1);
    endtask

    task automatic send_main(int a, int n);
        send_bits(a, 6); send_bits(n, 12); send_bit(1'b0);
    endtask

    task automatic pulse_load();
        @(negedge clk); ser_load = 1'b1;
        @(negedge clk); ser_load = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R6 reset state
        chk("R6 ref_ratio", int'(ref_ratio), 0);
        chk("R6 prog_cnt", int'(prog_cnt), 0);
        chk("R6 valids", int'({ref_valid, main_valid, ref_ok, main_ok}), 0);
        rst_n = 1'b1;

        // R3 reference word, R=5
        send_ref(5); pulse_load();
        chk("R3 ref_ratio=5", int'(ref_ratio), 5);
        chk("R7 ref_valid", int'(ref_valid), 1);
        chk("R7 main_valid still 0", int'(main_valid), 0);
        chk("R8 ref_ok at 5", int'(ref_ok), 1);

        // R2 main word
        send_main(3, 100); pulse_load();
        chk("R2 swallow", int'(swallow), 3);
        chk("R2 prog_cnt", int'(prog_cnt), 100);
        chk("R4 ref untouched", int'(ref_ratio), 5);
        chk("R9 main_ok", int'(main_ok), 1);

        // R5 shifting with load low
        send_ref(200);
        chk("R5 ref held", int'(ref_ratio), 5);
        chk("R5 main held", int'(prog_cnt), 100);
        pulse_load();
        chk("R4 ref loads 200", int'(ref_ratio), 200);

        // R1 serial clock held high while data toggles
        @(negedge clk); ser_clk = 1'b1; ser_data = 1'b0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); ser_data = ~ser_data; end
        @(negedge clk); ser_clk = 1'b0;
        // one edge happened: bit 0 entered; restore by sending ref again then checking
        send_ref(777); pulse_load();
        chk("R1 single shift per edge", int'(ref_ratio), 777);

        // R3 leading extra bits are ignored
        send_bits(13'h1abc, 13); send_ref(16383); pulse_load();
        chk("R3 ref max", int'(ref_ratio), 16383);
        chk("R8 ref_ok max", int'(ref_ok), 1);

        // R8 below minimum
        send_ref(4); pulse_load();
        chk("R8 ref_ok at 4", int'(ref_ok), 0);

        // R9 edges
        send_main(10, 10); pulse_load();
        chk("R9 A equals N", int'(main_ok), 0);
        send_main(0, 4); pulse_load();
        chk("R9 N=4", int'(main_ok), 0);
        send_main(63, 4095); pulse_load();
        chk("R2 swallow 63", int'(swallow), 63);
        chk("R9 max legal", int'(main_ok), 1);
        chk("R4 ref kept 4", int'(ref_ratio), 4);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule